// File: doc/BRIEF.md
# PS/2 Mouse Movement Packet Decoder

This block listens to the two open-collector lines of a PS/2 pointing device and turns its three-word movement reports into host-side values. It brings both lines into the system clock domain and detects the falling edges of the device clock. It frames each 11-bit word, checks the word's parity and stop bit, and groups the good bytes into packets of three. For each complete packet it presents the button states, signed 9-bit X and Y displacements and overflow flags, together with a single-cycle valid strobe.

The first byte of a packet is the status byte. Its sign bits are joined to the two magnitude bytes that follow to form two's-complement deltas. Movement to the right and movement upward give positive values. The decoder recovers from a broken stream by itself. It drops words that fail their checks, drops packets whose bytes are too far apart, and drops any status candidate that lacks its always-one marker bit.

Top module: `ps2_mouse_decoder`

## Requirements
- R1: While rst_ni is low, every output is 0: no strobes, buttons released, both deltas zero, both overflow flags clear.
- R2: A word begins at a falling edge of the device clock where the data line is 0. A falling edge with data high while no word is in progress is ignored. The next 8 falling edges sample the data bits, least significant bit first. The ninth samples the parity bit and the tenth samples the stop bit.
- R3: A word is good when its 8 data bits and its parity bit hold an odd number of ones and its stop bit is 1.
- R4: The status byte is decoded as follows. Bit 0 is the left button (1 = pressed) and bit 1 is the right button. Bit 3 is always 1. Bits 4 and 5 are the X and Y signs (1 = negative). Bits 6 and 7 are the X and Y overflow flags. The second byte is the X magnitude and the third byte is the Y magnitude.
- R5: After the third good byte of a packet, pkt_valid_o pulses for one cycle. In that same cycle dx_o becomes {X sign, X byte} and dy_o becomes {Y sign, Y byte}, and the button and overflow outputs take their status bits. All these outputs then hold until the next valid packet.
- R6: A byte in the status position whose bit 3 is 0 is discarded. The byte after it is again treated as a status candidate.
- R7: A word that fails the R3 checks pulses err_o for one cycle and discards the partial packet. The outputs keep their values, and the next good byte is a status candidate.
- R8: If more than GAP_CYCLES system cycles pass between two bytes of one packet, the partial packet is discarded. The next byte is then a status candidate.
- R9: If no falling edge arrives for BIT_TIMEOUT system cycles inside a word, the word is abandoned without an error pulse.
- R10: pkt_valid_o and err_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ps2_clk_i | input | 1 | Device clock line, raw |
| ps2_data_i | input | 1 | Device data line, raw |
| btn_left_o | output | 1 | Left button pressed |
| btn_right_o | output | 1 | Right button pressed |
| dx_o | output | 9 | X displacement, two's complement |
| dy_o | output | 9 | Y displacement, two's complement |
| x_ovf_o | output | 1 | X overflow flag |
| y_ovf_o | output | 1 | Y overflow flag |
| pkt_valid_o | output | 1 | One-cycle strobe on a decoded packet |
| err_o | output | 1 | One-cycle strobe on a bad word |

## Verification
Clean packets use asymmetric byte values with mixed sign, overflow and button bits. These patterns separate least-significant-first order from the reverse, expose a sign bit attached to the wrong axis, and separate -256 from +255. Damaged streams are each followed by a clean packet whose values would come out different if the damage leaked through. The damage cases are a stray byte with the marker bit clear, a bad parity word, a bad stop bit, an overlong gap between bytes, a word cut off midway, and a clock pulse with the data line high. After each damaged stream the bench checks the strobe counts and that the outputs held their previous values.

// File: rtl/ps2_mouse_pkg.sv
package ps2_mouse_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned WORD_BITS = 11;
  localparam int unsigned PKT_BYTES = 3;
  localparam int unsigned DELTA_W   = BYTE_W + 1;

  typedef struct packed {
    logic y_ovf;
    logic x_ovf;
    logic y_neg;
    logic x_neg;
    logic marker;
    logic rsvd;
    logic right;
    logic left;
  } status_t;
endpackage

// File: rtl/ps2_line_sync.sv
module ps2_line_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ps2_clk_i,
  input  logic ps2_data_i,
  output logic fall_o,
  output logic data_o
);
  logic [SYNC_STAGES-1:0] clk_q, dat_q;
  logic                   clk_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_q    <= '1;
      dat_q    <= '1;
      clk_last <= 1'b1;
    end else begin
      clk_q    <= {clk_q[SYNC_STAGES-2:0], ps2_clk_i};
      dat_q    <= {dat_q[SYNC_STAGES-2:0], ps2_data_i};
      clk_last <= clk_q[SYNC_STAGES-1];
    end
  end

  assign fall_o = clk_last & ~clk_q[SYNC_STAGES-1];
  assign data_o = dat_q[SYNC_STAGES-1];
endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
  import ps2_mouse_pkg::*;
#(
  parameter int unsigned BIT_TIMEOUT = 20000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fall_i,
  input  logic              data_i,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              frm_err_o
);
  localparam int unsigned CW = $clog2(WORD_BITS);
  localparam int unsigned TW = $clog2(BIT_TIMEOUT + 1);
  localparam logic [CW-1:0] LAST_BIT = CW'(WORD_BITS - 1);

  logic [CW-1:0]   bit_cnt;
  logic [BYTE_W:0] sh;      // parity in msb, data below
  logic [TW-1:0]   tmr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt    <= '0;
      sh         <= '0;
      tmr        <= '0;
      byte_vld_o <= 1'b0;
      frm_err_o  <= 1'b0;
      byte_o     <= '0;
    end else begin
      byte_vld_o <= 1'b0;
      frm_err_o  <= 1'b0;
      if (fall_i) begin
        tmr <= '0;
        if (bit_cnt == '0) begin
          if (!data_i) bit_cnt <= CW'(1);
        end else if (bit_cnt == LAST_BIT) begin
          bit_cnt <= '0;
          byte_o  <= sh[BYTE_W-1:0];
          if (data_i && (^sh)) byte_vld_o <= 1'b1;
          else                 frm_err_o  <= 1'b1;
        end else begin
          sh      <= {data_i, sh[BYTE_W:1]};
          bit_cnt <= bit_cnt + CW'(1);
        end
      end else if (bit_cnt != '0) begin
        if (tmr == TW'(BIT_TIMEOUT)) begin
          bit_cnt <= '0;
          tmr     <= '0;
        end else begin
          tmr <= tmr + TW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/ps2_pkt_asm.sv
module ps2_pkt_asm
  import ps2_mouse_pkg::*;
#(
  parameter int unsigned GAP_CYCLES = 200000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               byte_vld_i,
  input  logic [BYTE_W-1:0]  byte_i,
  input  logic               frm_err_i,
  output logic               btn_left_o,
  output logic               btn_right_o,
  output logic [DELTA_W-1:0] dx_o,
  output logic [DELTA_W-1:0] dy_o,
  output logic               x_ovf_o,
  output logic               y_ovf_o,
  output logic               pkt_valid_o,
  output logic               err_o
);
  localparam int unsigned IW = $clog2(PKT_BYTES);
  localparam int unsigned GW = $clog2(GAP_CYCLES + 1);

  logic [IW-1:0]     idx;
  status_t           st;
  logic [BYTE_W-1:0] x_mag;
  logic [GW-1:0]     gap;
  status_t           cand;

  assign cand = status_t'(byte_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx         <= '0;
      st          <= '0;
      x_mag       <= '0;
      gap         <= '0;
      btn_left_o  <= 1'b0;
      btn_right_o <= 1'b0;
      dx_o        <= '0;
      dy_o        <= '0;
      x_ovf_o     <= 1'b0;
      y_ovf_o     <= 1'b0;
      pkt_valid_o <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      pkt_valid_o <= 1'b0;
      err_o       <= 1'b0;
      if (frm_err_i) begin
        idx   <= '0;
        gap   <= '0;
        err_o <= 1'b1;
      end else if (byte_vld_i) begin
        gap <= '0;
        if (idx == '0) begin
          if (cand.marker) begin
            st  <= cand;
            idx <= IW'(1);
          end
        end else if (idx == IW'(1)) begin
          x_mag <= byte_i;
          idx   <= IW'(2);
        end else begin
          idx         <= '0;
          btn_left_o  <= st.left;
          btn_right_o <= st.right;
          dx_o        <= {st.x_neg, x_mag};
          dy_o        <= {st.y_neg, byte_i};
          x_ovf_o     <= st.x_ovf;
          y_ovf_o     <= st.y_ovf;
          pkt_valid_o <= 1'b1;
        end
      end else if (idx != '0) begin
        if (gap == GW'(GAP_CYCLES)) begin
          idx <= '0;
          gap <= '0;
        end else begin
          gap <= gap + GW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/ps2_mouse_decoder.sv
module ps2_mouse_decoder
  import ps2_mouse_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned BIT_TIMEOUT = 20000,
  parameter int unsigned GAP_CYCLES  = 200000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ps2_clk_i,
  input  logic               ps2_data_i,
  output logic               btn_left_o,
  output logic               btn_right_o,
  output logic [DELTA_W-1:0] dx_o,
  output logic [DELTA_W-1:0] dy_o,
  output logic               x_ovf_o,
  output logic               y_ovf_o,
  output logic               pkt_valid_o,
  output logic               err_o
);
  logic              fall, data;
  logic              byte_vld, frm_err;
  logic [BYTE_W-1:0] byte_q;

  ps2_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .ps2_clk_i, .ps2_data_i,
    .fall_o(fall), .data_o(data)
  );

  ps2_frame_rx #(.BIT_TIMEOUT(BIT_TIMEOUT)) u_frame (
    .clk_i, .rst_ni, .fall_i(fall), .data_i(data),
    .byte_vld_o(byte_vld), .byte_o(byte_q), .frm_err_o(frm_err)
  );

  ps2_pkt_asm #(.GAP_CYCLES(GAP_CYCLES)) u_asm (
    .clk_i, .rst_ni,
    .byte_vld_i(byte_vld), .byte_i(byte_q), .frm_err_i(frm_err),
    .btn_left_o, .btn_right_o, .dx_o, .dy_o, .x_ovf_o, .y_ovf_o,
    .pkt_valid_o, .err_o
  );
endmodule

// File: rtl/ps2_mouse_decoder_chk.sv
module ps2_mouse_decoder_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       btn_left_o,
  input logic       btn_right_o,
  input logic [8:0] dx_o,
  input logic [8:0] dy_o,
  input logic       x_ovf_o,
  input logic       y_ovf_o,
  input logic       pkt_valid_o,
  input logic       err_o
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_quiet_r1: assert (!pkt_valid_o && !err_o && dx_o == '0 && dy_o == '0
                                && !btn_left_o && !btn_right_o && !x_ovf_o && !y_ovf_o);
    end
  end

  p_valid_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o |=> !pkt_valid_o);

  p_hold_dx_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pkt_valid_o |-> $stable(dx_o) && $stable(dy_o));

  p_hold_flags_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pkt_valid_o |-> $stable({btn_left_o, btn_right_o, x_ovf_o, y_ovf_o}));

  p_err_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  p_strobe_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pkt_valid_o, err_o}));
endmodule

bind ps2_mouse_decoder ps2_mouse_decoder_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .btn_left_o(btn_left_o), .btn_right_o(btn_right_o),
  .dx_o(dx_o), .dy_o(dy_o), .x_ovf_o(x_ovf_o), .y_ovf_o(y_ovf_o),
  .pkt_valid_o(pkt_valid_o), .err_o(err_o)
);

// File: tb/ps2_mouse_decoder_test.sv
`timescale 1ns/1ps
module ps2_mouse_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 20;    // device clock half period in system cycles
  localparam int GAP        = 2000;
  localparam int BIT_TO     = 400;

  logic clk = 1'b0, rst_n = 1'b0, ps2_clk = 1'b1, ps2_dat = 1'b1;
  logic btn_l, btn_r, xo, yo, vld, err;
  logic [8:0] dx, dy;

  int n_checks = 0, n_fail = 0, n_vld = 0, n_err = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ps2_mouse_decoder #(.BIT_TIMEOUT(BIT_TO), .GAP_CYCLES(GAP)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ps2_clk_i(ps2_clk), .ps2_data_i(ps2_dat),
    .btn_left_o(btn_l), .btn_right_o(btn_r), .dx_o(dx), .dy_o(dy),
    .x_ovf_o(xo), .y_ovf_o(yo), .pkt_valid_o(vld), .err_o(err)
  );

  always @(posedge clk) begin
    if (vld) n_vld++;
    if (err) n_err++;
  end

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    ps2_dat = b; cyc(HALF);
    ps2_clk = 1'b0; cyc(HALF);
    ps2_clk = 1'b1;
  endtask

  task automatic send_word(logic [7:0] b, bit bad_par = 0, bit bad_stop = 0);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
    send_bit(~(^b) ^ bad_par);
    send_bit(~bad_stop);
    ps2_dat = 1'b1;
    cyc(100);
  endtask

  task automatic send_pkt(logic [7:0] s, logic [7:0] x, logic [7:0] y);
    send_word(s); send_word(x); send_word(y);
    cyc(20);
  endtask

  task automatic expect_out(string req, int l, int r, int ex, int ey, int ox, int oy);
    chk({req, " left"}, btn_l, l);
    chk({req, " right"}, btn_r, r);
    chk({req, " dx"}, dx, ex);
    chk({req, " dy"}, dy, ey);
    chk({req, " xovf"}, xo, ox);
    chk({req, " yovf"}, yo, oy);
  endtask

  task automatic t_reset_r1();
    cyc(3);
    expect_out("R1", 0, 0, 0, 0, 0, 0);
    chk("R1 valid", vld, 0);
    chk("R1 err", err, 0);
    rst_n = 1'b1;
    cyc(5);
  endtask

  task automatic t_basic_r4();
    int v0 = n_vld, e0 = n_err;
    send_pkt(8'h29, 8'h05, 8'hF0);   // L, Y negative
    chk("R5 count", n_vld - v0, 1);
    chk("R3 no err", n_err - e0, 0);
    expect_out("R4", 1, 0, 9'h005, 9'h1F0, 0, 0);
  endtask

  task automatic t_extremes_r4();
    int v0 = n_vld;
    send_pkt(8'h5A, 8'h00, 8'hFF);   // R, X negative, X overflow
    chk("R5 count", n_vld - v0, 1);
    expect_out("R4", 0, 1, 9'h100, 9'h0FF, 1, 0);
  endtask

  task automatic t_resync_r6();
    int v0 = n_vld;
    send_word(8'h02);                // marker clear: dropped
    send_pkt(8'h0B, 8'h80, 8'h01);
    chk("R6 count", n_vld - v0, 1);
    expect_out("R6", 1, 1, 9'h080, 9'h001, 0, 0);
  endtask

  task automatic t_parity_r7();
    int v0 = n_vld, e0 = n_err;
    send_word(8'h08); send_word(8'h33, 1); send_word(8'h01);
    cyc(20);
    chk("R7 err count", n_err - e0, 1);
    chk("R7 no valid", n_vld - v0, 0);
    expect_out("R7 hold", 1, 1, 9'h080, 9'h001, 0, 0);
    send_pkt(8'h38, 8'h10, 8'h20);
    chk("R7 recover", n_vld - v0, 1);
    expect_out("R7", 0, 0, 9'h110, 9'h120, 0, 0);
  endtask

  task automatic t_stop_r3();
    int v0 = n_vld, e0 = n_err;
    send_word(8'hC8); send_word(8'h11); send_word(8'h22, 0, 1);
    cyc(20);
    chk("R3 stop err", n_err - e0, 1);
    chk("R3 no valid", n_vld - v0, 0);
    expect_out("R3 hold", 0, 0, 9'h110, 9'h120, 0, 0);
    send_pkt(8'hC8, 8'h11, 8'h22);
    chk("R3 recover", n_vld - v0, 1);
    expect_out("R3", 0, 0, 9'h011, 9'h022, 1, 1);
  endtask

  task automatic t_gap_r8();
    int v0 = n_vld;
    send_word(8'h09); send_word(8'h44);
    cyc(GAP + 1000);
    send_pkt(8'h18, 8'h7F, 8'h00);
    chk("R8 count", n_vld - v0, 1);
    expect_out("R8", 0, 0, 9'h17F, 9'h000, 0, 0);
  endtask

  task automatic t_bit_timeout_r9();
    int v0 = n_vld, e0 = n_err;
    send_bit(1'b0);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    ps2_dat = 1'b1;
    cyc(BIT_TO + 600);
    send_pkt(8'h08, 8'h03, 8'h04);
    chk("R9 count", n_vld - v0, 1);
    chk("R9 no err", n_err - e0, 0);
    expect_out("R9", 0, 0, 9'h003, 9'h004, 0, 0);
  endtask

  task automatic t_idle_high_r2();
    int v0 = n_vld, e0 = n_err;
    send_bit(1'b1);                  // no start bit
    ps2_dat = 1'b1;
    cyc(100);
    send_pkt(8'h0A, 8'h06, 8'h07);
    chk("R2 count", n_vld - v0, 1);
    chk("R2 no err", n_err - e0, 0);
    expect_out("R2", 0, 1, 9'h006, 9'h007, 0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    t_reset_r1();
    t_basic_r4();
    t_extremes_r4();
    t_resync_r6();
    t_parity_r7();
    t_stop_r3();
    t_gap_r8();
    t_bit_timeout_r9();
    t_idle_high_r2();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule